// File: doc/BRIEF.md
# Warm-Reset Control System Register

This block is one 64-bit system control register for a core whose top privilege level is EL1. It also holds the logic that decodes accesses to that register and the logic that asks a reset controller for a warm reset. The core's execute stage presents each system-register read or write as an encoding tuple, with the current exception level and the write data. When the tuple names this register, the block answers one cycle later. The answer is either the read data or an undefined-instruction flag.

Two bits carry state. The request bit starts a warm reset. The boot-state bit tells the reset controller whether the core restarts in the 32-bit or the 64-bit execution state, and the controller samples the `boot_aa64` output when the warm reset is released. Only a cold reset reinitialises the boot-state bit. A warm reset clears the request state and nothing else.

A parameter removes 32-bit support, which makes the boot-state bit a constant one. Another parameter chooses the request output's form: a single-cycle pulse, or a level held until the controller acknowledges it.

Top module: `rstctl_sysreg`

## Requirements
- R1: The block responds (`resp_valid` high one cycle later) only to accesses whose encoding is op0=0b11, op1=0b000, CRn=0b1100, CRm=0b0000, op2=0b010; any other encoding gets no response and changes nothing.
- R2: An allowed read returns, one cycle after the access, a 64-bit word with the request bit at bit 1 and the boot-state bit at bit 0, taken from the state before any change in that cycle.
- R3: An access is allowed only when `cur_el` is 1 and the highest implemented level is 1. Otherwise `resp_undef` is high with `rd_data` zero, and neither register state nor the request output changes.
- R4: With 32-bit support, the boot-state bit (bit 0, 1 = 64-bit, 0 = 32-bit) takes write data bit 0 on an allowed write and is driven on `boot_aa64`.
- R5: Without 32-bit support, bit 0 and `boot_aa64` always read 1 and writes to bit 0 are ignored.
- R6: A warm reset clears the request bit and the request output, and it leaves the boot-state bit unchanged.
- R7: In level mode, an allowed write with data bit 1 set raises `wrst_req` in the next cycle. It stays high until the cycle after `wrst_ack` is sampled high, and a new request wins over a simultaneous acknowledge.
- R8: In pulse mode, each allowed write with data bit 1 set gives `wrst_req` high for exactly the following cycle, and `wrst_ack` has no effect.
- R9: After a cold reset the boot-state bit is 1, and the request bit, `wrst_req`, `resp_valid`, `resp_undef` and `rd_data` are all 0.
- R10: Bits 63 to 2 always read as zero, whatever was written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| cold_rst | input | 1 | Synchronous active-high cold reset |
| warm_rst | input | 1 | Synchronous active-high warm reset |
| acc_valid | input | 1 | System-register access presented this cycle |
| acc_write | input | 1 | 1 = write form, 0 = read form |
| acc_op0 | input | 2 | Encoding field op0 |
| acc_op1 | input | 3 | Encoding field op1 |
| acc_crn | input | 4 | Encoding field CRn |
| acc_crm | input | 4 | Encoding field CRm |
| acc_op2 | input | 3 | Encoding field op2 |
| cur_el | input | 2 | Current exception level |
| acc_wdata | input | 64 | Write data |
| wrst_ack | input | 1 | Reset controller accepted the request (level mode) |
| resp_valid | output | 1 | Access to this register answered |
| resp_undef | output | 1 | Access rejected as undefined |
| rd_data | output | 64 | Read data, zero unless an allowed read |
| wrst_req | output | 1 | Warm-reset request |
| boot_aa64 | output | 1 | Boot-state selection for the next warm reset |

## Verification
The bench builds two copies side by side and drives them with the same stimulus. The first copy has 32-bit support and the level-held request. The second has the boot-state bit fixed at one and the single-cycle request pulse. Between them the two copies cover every variant of both the boot-state storage and the request generator. Both copies keep the highest level at EL1, so rejected accesses come only from `cur_el` values other than 1.

// File: rtl/rmr_pkg.sv
package rmr_pkg;
  typedef struct packed {
    logic [1:0] op0;
    logic [2:0] op1;
    logic [3:0] crn;
    logic [3:0] crm;
    logic [2:0] op2;
  } sysreg_enc_t;

  localparam sysreg_enc_t RMR_ENC = '{op0: 2'b11, op1: 3'b000, crn: 4'b1100,
                                      crm: 4'b0000, op2: 3'b010};
  localparam int REQ_POS  = 1;
  localparam int BOOT_POS = 0;
endpackage

// File: rtl/rmr_access_dec.sv
module rmr_access_dec #(
  parameter int EL_W       = 2,
  parameter int HIGHEST_EL = 1,
  parameter int OWNER_EL   = 1
) (
  input  logic                 acc_valid,
  input  logic                 acc_write,
  input  rmr_pkg::sysreg_enc_t enc,
  input  logic [EL_W-1:0]      cur_el,
  output logic                 hit,
  output logic                 rd_ok,
  output logic                 wr_ok,
  output logic                 undef
);
  localparam logic TOP_IS_OWNER = (HIGHEST_EL == OWNER_EL);

  logic level_ok;

  always_comb begin
    hit      = acc_valid && (enc == rmr_pkg::RMR_ENC);
    level_ok = TOP_IS_OWNER && (cur_el == EL_W'(OWNER_EL));
    rd_ok    = hit && level_ok && !acc_write;
    wr_ok    = hit && level_ok && acc_write;
    undef    = hit && !level_ok;
  end
endmodule

// File: rtl/rmr_state_regs.sv
module rmr_state_regs #(
  parameter int DATA_W      = 64,
  parameter bit SUPPORTS_32 = 1'b1
) (
  input  logic              clk,
  input  logic              cold_rst,
  input  logic              warm_rst,
  input  logic              wr_ok,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] view
);
  localparam logic [DATA_W-1:0] REQ_M  = DATA_W'(1) << rmr_pkg::REQ_POS;
  localparam logic [DATA_W-1:0] BOOT_M = DATA_W'(1) << rmr_pkg::BOOT_POS;
  localparam logic [DATA_W-1:0] WR_M   = SUPPORTS_32 ? (REQ_M | BOOT_M) : REQ_M;
  localparam logic [DATA_W-1:0] COLD_V = BOOT_M;

  logic [DATA_W-1:0] val_q;

  always_ff @(posedge clk) begin
    if (cold_rst)
      val_q <= COLD_V;
    else if (warm_rst)
      val_q <= val_q & ~REQ_M;
    else if (wr_ok)
      val_q <= (wdata & WR_M) | (val_q & ~WR_M);
  end

  assign view = val_q;
endmodule

// File: rtl/rmr_req_gen.sv
module rmr_req_gen #(
  parameter bit PULSE_MODE = 1'b0
) (
  input  logic clk,
  input  logic cold_rst,
  input  logic warm_rst,
  input  logic set_req,
  input  logic ack,
  output logic req_q
);
  generate
    if (PULSE_MODE) begin : g_pulse
      logic unused_ack;
      assign unused_ack = ack;
      always_ff @(posedge clk) begin
        if (cold_rst || warm_rst) req_q <= 1'b0;
        else                      req_q <= set_req;
      end
    end else begin : g_level
      always_ff @(posedge clk) begin
        if (cold_rst || warm_rst) req_q <= 1'b0;
        else if (set_req)         req_q <= 1'b1;
        else if (ack)             req_q <= 1'b0;
      end
    end
  endgenerate
endmodule

// File: rtl/rstctl_sysreg.sv
module rstctl_sysreg #(
  parameter int DATA_W      = 64,
  parameter int EL_W        = 2,
  parameter int HIGHEST_EL  = 1,
  parameter bit SUPPORTS_32 = 1'b1,
  parameter bit PULSE_MODE  = 1'b0
) (
  input  logic              clk,
  input  logic              cold_rst,
  input  logic              warm_rst,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [1:0]        acc_op0,
  input  logic [2:0]        acc_op1,
  input  logic [3:0]        acc_crn,
  input  logic [3:0]        acc_crm,
  input  logic [2:0]        acc_op2,
  input  logic [EL_W-1:0]   cur_el,
  input  logic [DATA_W-1:0] acc_wdata,
  input  logic              wrst_ack,
  output logic              resp_valid,
  output logic              resp_undef,
  output logic [DATA_W-1:0] rd_data,
  output logic              wrst_req,
  output logic              boot_aa64
);
  rmr_pkg::sysreg_enc_t enc;
  logic hit, rd_ok, wr_ok, undef;
  logic [DATA_W-1:0] view;

  assign enc = '{op0: acc_op0, op1: acc_op1, crn: acc_crn, crm: acc_crm, op2: acc_op2};

  rmr_access_dec #(.EL_W(EL_W), .HIGHEST_EL(HIGHEST_EL), .OWNER_EL(1)) u_dec (
    .acc_valid(acc_valid), .acc_write(acc_write), .enc(enc), .cur_el(cur_el),
    .hit(hit), .rd_ok(rd_ok), .wr_ok(wr_ok), .undef(undef)
  );

  rmr_state_regs #(.DATA_W(DATA_W), .SUPPORTS_32(SUPPORTS_32)) u_regs (
    .clk(clk), .cold_rst(cold_rst), .warm_rst(warm_rst),
    .wr_ok(wr_ok), .wdata(acc_wdata), .view(view)
  );

  rmr_req_gen #(.PULSE_MODE(PULSE_MODE)) u_req (
    .clk(clk), .cold_rst(cold_rst), .warm_rst(warm_rst),
    .set_req(wr_ok && acc_wdata[rmr_pkg::REQ_POS]), .ack(wrst_ack), .req_q(wrst_req)
  );

  always_ff @(posedge clk) begin
    if (cold_rst || warm_rst) begin
      resp_valid <= 1'b0;
      resp_undef <= 1'b0;
      rd_data    <= '0;
    end else begin
      resp_valid <= hit;
      resp_undef <= undef;
      rd_data    <= rd_ok ? view : '0;
    end
  end

  assign boot_aa64 = view[rmr_pkg::BOOT_POS];
endmodule

// File: rtl/rmr_sva.sv
module rmr_sva #(
  parameter int DATA_W      = 64,
  parameter bit SUPPORTS_32 = 1'b1,
  parameter bit PULSE_MODE  = 1'b0
) (
  input logic              clk,
  input logic              cold_rst,
  input logic              warm_rst,
  input logic              acc_valid,
  input logic              acc_write,
  input logic              req_bit,
  input logic              wrst_ack,
  input logic              resp_valid,
  input logic              resp_undef,
  input logic [DATA_W-1:0] rd_data,
  input logic              wrst_req,
  input logic              boot_aa64
);
  AST_UNDEF_ZERO_DATA: assert property (@(posedge clk) disable iff (cold_rst)
    resp_undef |-> rd_data == '0); // R3
  AST_UNDEF_IS_RESPONSE: assert property (@(posedge clk) disable iff (cold_rst)
    resp_undef |-> resp_valid); // R3
  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (cold_rst)
    rd_data[DATA_W-1:2] == '0); // R10
  AST_WARM_KEEPS_BOOT: assert property (@(posedge clk) disable iff (cold_rst)
    warm_rst |=> $stable(boot_aa64)); // R6
  AST_WARM_DROPS_REQ: assert property (@(posedge clk) disable iff (cold_rst)
    warm_rst |=> !wrst_req); // R6
  AST_FIXED_BOOT: assert property (@(posedge clk) disable iff (cold_rst)
    !SUPPORTS_32 |-> boot_aa64); // R5
  AST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (cold_rst)
    (PULSE_MODE && wrst_req) |-> $past(acc_valid && acc_write && req_bit)); // R8
  AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (cold_rst)
    (!PULSE_MODE && wrst_req && !wrst_ack && !warm_rst) |=> wrst_req); // R7
endmodule

bind rstctl_sysreg rmr_sva #(.DATA_W(DATA_W), .SUPPORTS_32(SUPPORTS_32), .PULSE_MODE(PULSE_MODE)) u_sva (
  .clk(clk), .cold_rst(cold_rst), .warm_rst(warm_rst), .acc_valid(acc_valid),
  .acc_write(acc_write), .req_bit(acc_wdata[1]), .wrst_ack(wrst_ack),
  .resp_valid(resp_valid), .resp_undef(resp_undef), .rd_data(rd_data),
  .wrst_req(wrst_req), .boot_aa64(boot_aa64)
);

// File: tb/rstctl_sysreg_tb_top.sv
module rstctl_sysreg_tb_top;
  logic clk = 1'b0;
  always #2ns clk = ~clk;

  logic        cold_rst = 1'b1, warm_rst = 1'b0;
  logic        acc_valid = 1'b0, acc_write = 1'b0, wrst_ack = 1'b0;
  logic [1:0]  acc_op0 = 2'b11;
  logic [2:0]  acc_op1 = 3'b000;
  logic [3:0]  acc_crn = 4'b1100;
  logic [3:0]  acc_crm = 4'b0000;
  logic [2:0]  acc_op2 = 3'b010;
  logic [1:0]  cur_el = 2'd1;
  logic [63:0] acc_wdata = '0;

  logic        o_rv [2];
  logic        o_ru [2];
  logic [63:0] o_rd [2];
  logic        o_req[2];
  logic        o_boot[2];

  rstctl_sysreg dut_i (
    .clk(clk), .cold_rst(cold_rst), .warm_rst(warm_rst), .acc_valid(acc_valid),
    .acc_write(acc_write), .acc_op0(acc_op0), .acc_op1(acc_op1), .acc_crn(acc_crn),
    .acc_crm(acc_crm), .acc_op2(acc_op2), .cur_el(cur_el), .acc_wdata(acc_wdata),
    .wrst_ack(wrst_ack), .resp_valid(o_rv[0]), .resp_undef(o_ru[0]), .rd_data(o_rd[0]),
    .wrst_req(o_req[0]), .boot_aa64(o_boot[0])
  );

  rstctl_sysreg #(.SUPPORTS_32(1'b0), .PULSE_MODE(1'b1)) dut_b_i (
    .clk(clk), .cold_rst(cold_rst), .warm_rst(warm_rst), .acc_valid(acc_valid),
    .acc_write(acc_write), .acc_op0(acc_op0), .acc_op1(acc_op1), .acc_crn(acc_crn),
    .acc_crm(acc_crm), .acc_op2(acc_op2), .cur_el(cur_el), .acc_wdata(acc_wdata),
    .wrst_ack(wrst_ack), .resp_valid(o_rv[1]), .resp_undef(o_ru[1]), .rd_data(o_rd[1]),
    .wrst_req(o_req[1]), .boot_aa64(o_boot[1])
  );

  int vectors = 0;
  int miscompares = 0;
  bit started = 1'b0;
  bit done = 1'b0;

  // Behavioural reference: copy 0 = 32-bit capable, level request; copy 1 = fixed boot, pulse
  bit          m_boot[2], m_rr[2], m_req[2], m_rv[2], m_ru[2];
  logic [63:0] m_rd[2];

  task automatic check(input logic [63:0] act, input logic [63:0] exp, input string tag);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
    end
  endtask

  always @(posedge clk) begin
    started <= 1'b1;
    for (int k = 0; k < 2; k++) begin
      bit s32, pulse, hit, ok, setr;
      s32   = (k == 0);
      pulse = (k == 1);
      if (cold_rst) begin
        m_boot[k] = 1; m_rr[k] = 0; m_req[k] = 0; m_rv[k] = 0; m_ru[k] = 0; m_rd[k] = '0;
      end else if (warm_rst) begin
        m_rr[k] = 0; m_req[k] = 0; m_rv[k] = 0; m_ru[k] = 0; m_rd[k] = '0;
      end else begin
        hit = acc_valid && acc_op0 == 2'b11 && acc_op1 == 3'b000 && acc_crn == 4'b1100
              && acc_crm == 4'b0000 && acc_op2 == 3'b010;
        ok  = hit && cur_el == 2'd1;
        m_rv[k] = hit;
        m_ru[k] = hit && !ok;
        m_rd[k] = (ok && !acc_write) ? {62'd0, m_rr[k], m_boot[k]} : 64'd0;
        setr = ok && acc_write && acc_wdata[1];
        if (ok && acc_write) begin
          m_rr[k] = acc_wdata[1];
          if (s32) m_boot[k] = acc_wdata[0];
        end
        if (pulse)         m_req[k] = setr;
        else if (setr)     m_req[k] = 1;
        else if (wrst_ack) m_req[k] = 0;
      end
    end
  end

  always @(negedge clk) begin
    if (started && !done) begin
      for (int k = 0; k < 2; k++) begin
        check({63'd0, o_rv[k]},   {63'd0, m_rv[k]},   "R1 resp_valid");
        check({63'd0, o_ru[k]},   {63'd0, m_ru[k]},   "R3 resp_undef");
        check(o_rd[k],            m_rd[k],            "R2 rd_data");
        check({63'd0, o_boot[k]}, {63'd0, m_boot[k]}, k == 0 ? "R4 boot_aa64" : "R5 boot_aa64");
        check({63'd0, o_req[k]},  {63'd0, m_req[k]},  k == 0 ? "R7 wrst_req" : "R8 wrst_req");
      end
    end
  end

  task automatic cyc(input bit v, input bit w, input bit good, input logic [1:0] el,
                     input logic [63:0] d, input bit ack);
    @(negedge clk);
    acc_valid = v; acc_write = w; cur_el = el; acc_wdata = d; wrst_ack = ack;
    acc_crm = good ? 4'b0000 : 4'b0001;
  endtask

  task automatic idle();
    cyc(1'b0, 1'b0, 1'b1, 2'd1, 64'd0, 1'b0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    cold_rst = 1'b0;
    idle();
    // R9: cold reset state
    check({o_boot[0], o_req[0], o_rv[0], o_ru[0]}, 64'b1000, "R9 cold state");
    check(o_rd[0], 64'd0, "R9 cold rd_data");
    cyc(1, 0, 1, 2'd1, 64'd0, 0); idle();
    check(o_rd[0], 64'd1, "R2 read after cold");
    cyc(1, 1, 1, 2'd1, 64'd0, 0); idle();
    check({63'd0, o_boot[0]}, 64'd0, "R4 boot written 0");
    check({63'd0, o_boot[1]}, 64'd1, "R5 boot fixed");
    cyc(1, 1, 1, 2'd0, 64'd3, 0); idle();
    check({o_ru[0], o_req[0], o_boot[0]}, 64'b100, "R3 EL0 write rejected");
    cyc(1, 1, 1, 2'd2, 64'd3, 0); idle();
    check({o_ru[0], o_req[0], o_boot[0]}, 64'b100, "R3 EL2 write rejected");
    cyc(1, 1, 0, 2'd1, 64'd3, 0); idle();
    check({o_rv[0], o_req[0], o_boot[0]}, 64'b000, "R1 other encoding ignored");
    cyc(1, 1, 1, 2'd1, '1, 0);
    cyc(1, 0, 1, 2'd1, 64'd0, 0);
    check({o_req[0], o_req[1]}, 64'b11, "R7 R8 request raised");
    idle();
    check(o_rd[0], 64'd3, "R10 reserved bits read zero");
    check({63'd0, o_req[1]}, 64'd0, "R8 pulse ended");
    repeat (3) idle();
    check({63'd0, o_req[0]}, 64'd1, "R7 level held");
    cyc(0, 0, 1, 2'd1, 64'd0, 1); idle();
    check({63'd0, o_req[0]}, 64'd0, "R7 ack drops request");
    cyc(1, 1, 1, 2'd1, 64'd2, 0);
    @(negedge clk); warm_rst = 1'b1; acc_valid = 1'b0;
    @(negedge clk); warm_rst = 1'b0;
    check({o_req[0], o_boot[0]}, 64'b00, "R6 warm keeps boot, drops request");
    cyc(1, 0, 1, 2'd1, 64'd0, 0); idle();
    check(o_rd[0], 64'd0, "R6 request bit cleared");
    @(negedge clk); cold_rst = 1'b1;
    @(negedge clk); cold_rst = 1'b0;
    check({63'd0, o_boot[0]}, 64'd1, "R9 cold restores boot");
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      cold_rst  = ($urandom_range(0, 99) == 0);
      warm_rst  = ($urandom_range(0, 29) == 0);
      acc_valid = $urandom_range(0, 1);
      acc_write = $urandom_range(0, 1);
      acc_crm   = ($urandom_range(0, 4) == 0) ? 4'b0100 : 4'b0000;
      cur_el    = ($urandom_range(0, 2) == 0) ? 2'($urandom_range(0, 3)) : 2'd1;
      acc_wdata = {$urandom, $urandom};
      wrst_ack  = ($urandom_range(0, 3) == 0);
    end
    @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule